// File: doc/BRIEF.md
# Hopping Phase Step Bank

This block holds a small set of preset phase steps and feeds one of them, chosen at run time, into a phase accumulator. The accumulator output is the phase word of a numerically controlled oscillator. Software or a configuration engine loads the steps through a simple address/data write port. An external slot controller then moves the carrier between frequencies by driving the select input.

The accumulator is never cleared or reloaded when the selection moves. Only its step size changes, so the carrier phase stays continuous across every hop. A registered read port returns the stored step at any address, which lets the bank's contents be checked. Sine lookup after the phase word, and the timing of the hops, are handled outside the block.

Top module: `phase_hop_bank`

## Requirements
- R1: While rstN is low, phaseOut, rdData and every stored step are zero. Every address read after reset returns zero.
- R2: On each rising clock edge, phaseOut becomes its previous value plus the active step, modulo 2^PHASE_W.
- R3: On an edge where wrEn is high and the 4-bit wrAddr is below NUM_REGS, wrData is stored in the register at wrAddr.
- R4: A write whose wrAddr is NUM_REGS or above changes no stored step, including the steps at lower addresses.
- R5: The value of selIn is captured on an edge. It becomes the active step index for the accumulation made on the following edge.
- R6: A captured selIn of NUM_REGS or above makes the active step zero, so phaseOut holds its value.
- R7: A change of selIn never loads or clears the accumulator. After a hop, the phase continues from the value reached under the previous step.
- R8: A write to the register that is currently selected is used as the step from the accumulation on the next edge onward.
- R9: On an edge with rdEn high, rdData loads the step stored at rdAddr. If rdAddr is NUM_REGS or above, it loads zero. A write to the same address on the same edge is not yet visible. rdData holds its value on edges without rdEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the step registers |
| wrAddr | input | 4 | Write address |
| wrData | input | PHASE_W | Step value to store |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 4 | Read address |
| rdData | output | PHASE_W | Registered read data |
| selIn | input | 4 | Index of the step that drives the accumulator |
| phaseOut | output | PHASE_W | Accumulated phase word |

## Verification
The bench builds the block with NUM_REGS set to 12 and PHASE_W set to 16. With 12 registers, addresses 12 to 15 exist on the 4-bit ports but lie outside the bank. This exercises the ignored writes, the zero reads and the frozen phase on out-of-range selects. The 16-bit phase word wraps within a few cycles under large steps, so modulo accumulation is covered many times. Random hops, writes and reads are mixed with directed cases: a hop on a single edge, writing the active register, and reading and writing one address on the same edge.

// File: rtl/phase_hop_pkg.sv
package phase_hop_pkg;
  localparam int ADDR_W   = 4;
  localparam int MAX_REGS = 1 << ADDR_W;

  typedef struct packed {
    logic              wrLoad;
    logic [ADDR_W-1:0] wrIdx;
    logic              rdLoad;
    logic              rdInRange;
    logic [ADDR_W-1:0] rdIdx;
    logic              selInRange;
    logic [ADDR_W-1:0] selIdx;
  } hopCtrl_t;
endpackage

// File: rtl/phase_hop_ctrl.sv
module phase_hop_ctrl
  import phase_hop_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] selIn,
  output hopCtrl_t          ctrl
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(NUM_REGS);

  logic [ADDR_W-1:0] selQ;
  logic              selOkQ;

  // Select is captured once; the captured index steers the next accumulation.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ   <= '0;
      selOkQ <= 1'b1;
    end else begin
      selQ   <= selIn;
      selOkQ <= ({1'b0, selIn} < LIMIT);
    end
  end

  always_comb begin
    ctrl.wrLoad     = wrEn && ({1'b0, wrAddr} < LIMIT);
    ctrl.wrIdx      = wrAddr;
    ctrl.rdLoad     = rdEn;
    ctrl.rdInRange  = ({1'b0, rdAddr} < LIMIT);
    ctrl.rdIdx      = rdAddr;
    ctrl.selInRange = selOkQ;
    ctrl.selIdx     = selQ;
  end
endmodule

// File: rtl/phase_hop_datapath.sv
module phase_hop_datapath
  import phase_hop_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int PHASE_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  hopCtrl_t           ctrl,
  input  logic [PHASE_W-1:0] wrData,
  output logic [PHASE_W-1:0] phaseOut,
  output logic [PHASE_W-1:0] rdData,
  output logic [PHASE_W-1:0] activeStep
);
  logic [PHASE_W-1:0] bank [NUM_REGS];
  logic [PHASE_W-1:0] accQ;
  logic [PHASE_W-1:0] rdMux;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bank[g] <= '0;
      end else if (ctrl.wrLoad && (ctrl.wrIdx == ADDR_W'(g))) begin
        bank[g] <= wrData;
      end
    end
  end

  // Explicit selection loops keep indices in range for any NUM_REGS.
  always_comb begin
    activeStep = '0;
    rdMux      = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ctrl.selInRange && (ctrl.selIdx == ADDR_W'(i))) activeStep = bank[i];
      if (ctrl.rdInRange && (ctrl.rdIdx == ADDR_W'(i)))   rdMux      = bank[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ   <= '0;
      rdData <= '0;
    end else begin
      accQ <= accQ + activeStep;
      if (ctrl.rdLoad) rdData <= rdMux;
    end
  end

  assign phaseOut = accQ;
endmodule

// File: rtl/phase_hop_bank.sv
module phase_hop_bank
  import phase_hop_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int PHASE_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [3:0]         wrAddr,
  input  logic [PHASE_W-1:0] wrData,
  input  logic               rdEn,
  input  logic [3:0]         rdAddr,
  output logic [PHASE_W-1:0] rdData,
  input  logic [3:0]         selIn,
  output logic [PHASE_W-1:0] phaseOut
);
  hopCtrl_t           ctrl;
  logic [PHASE_W-1:0] activeStep;

  phase_hop_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .rdEn(rdEn), .rdAddr(rdAddr), .selIn(selIn), .ctrl(ctrl)
  );

  phase_hop_datapath #(.NUM_REGS(NUM_REGS), .PHASE_W(PHASE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrData(wrData),
    .phaseOut(phaseOut), .rdData(rdData), .activeStep(activeStep)
  );
endmodule

// File: rtl/phase_hop_bank_chk.sv
module phase_hop_bank_chk #(
  parameter int NUM_REGS = 16,
  parameter int PHASE_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [3:0]         wrAddr,
  input logic [PHASE_W-1:0] wrData,
  input logic               rdEn,
  input logic [3:0]         rdAddr,
  input logic [PHASE_W-1:0] rdData,
  input logic [3:0]         selIn,
  input logic [PHASE_W-1:0] phaseOut,
  input logic [PHASE_W-1:0] activeStep
);
  localparam logic [4:0] LIMIT = 5'(NUM_REGS);
  logic pastValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> phaseOut == PHASE_W'($past(phaseOut) + $past(activeStep))); // R2

  AST_OOR_SELECT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && ({1'b0, $past(selIn)} >= LIMIT)) |-> activeStep == '0); // R6

  AST_SELECTED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr == selIn) && ({1'b0, wrAddr} < LIMIT)) |=> activeStep == $past(wrData)); // R8

  AST_READ_OOR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && ({1'b0, rdAddr} >= LIMIT)) |=> rdData == '0); // R9

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R9
endmodule

bind phase_hop_bank phase_hop_bank_chk #(.NUM_REGS(NUM_REGS), .PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .selIn(selIn),
  .phaseOut(phaseOut), .activeStep(activeStep)
);

// File: tb/phase_hop_bank_tb.sv
`timescale 1ns/1ps
module phase_hop_bank_tb;
  localparam int N = 12;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [3:0]   wrAddr = '0;
  logic [W-1:0] wrData = '0;
  logic         rdEn = 1'b0;
  logic [3:0]   rdAddr = '0;
  logic [W-1:0] rdData;
  logic [3:0]   selIn = '0;
  logic [W-1:0] phaseOut;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] mBank [16];
  logic [3:0]   mSel;
  logic [W-1:0] mAcc;
  logic [W-1:0] mRd;

  always #4 clk = ~clk;

  phase_hop_bank #(.NUM_REGS(N), .PHASE_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .selIn(selIn), .phaseOut(phaseOut)
  );

  function automatic logic [W-1:0] stepOf(input logic [3:0] idx);
    return (int'(idx) < N) ? mBank[idx] : '0;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (phaseOut !== mAcc) begin
      errors++;
      $display("FAIL %s phaseOut actual %h expected %h", tag, phaseOut, mAcc);
    end
    checks++;
    if (rdData !== mRd) begin
      errors++;
      $display("FAIL %s rdData actual %h expected %h", tag, rdData, mRd);
    end
  endtask

  task automatic tick(input logic we, input logic [3:0] wa, input logic [W-1:0] wd,
                      input logic re, input logic [3:0] ra, input logic [3:0] sel,
                      input string tag);
    logic [W-1:0] nextAcc;
    wrEn = we; wrAddr = wa; wrData = wd; rdEn = re; rdAddr = ra; selIn = sel;
    @(posedge clk);
    nextAcc = mAcc + stepOf(mSel);
    if (re) mRd = stepOf(ra);
    if (we && int'(wa) < N) mBank[wa] = wd;
    mSel = sel;
    mAcc = nextAcc;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] s;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) mBank[i] = '0;
    mSel = '0; mAcc = '0; mRd = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rstN = 1'b1;
    // R1: every address reads zero after reset
    for (int a = 0; a < 16; a++) tick(1'b0, 4'd0, '0, 1'b1, 4'(a), 4'd0, "R1 readback");
    // R3: load every in-range register and read back
    for (int a = 0; a < N; a++) tick(1'b1, 4'(a), W'(a * 16'h1111 + 16'h0101), 1'b0, 4'd0, 4'd0, "R3 write");
    for (int a = 0; a < N; a++) tick(1'b0, 4'd0, '0, 1'b1, 4'(a), 4'd0, "R3 readback");
    // R4: writes above the bank change nothing
    for (int a = N; a < 16; a++) tick(1'b1, 4'(a), 16'hFFFF, 1'b0, 4'd0, 4'd0, "R4 ignored write");
    for (int a = 0; a < 16; a++) tick(1'b0, 4'd0, '0, 1'b1, 4'(a), 4'd0, "R4 readback");
    // R5: hop to register 3, new step appears one edge later
    tick(1'b0, 4'd0, '0, 1'b0, 4'd0, 4'd3, "R5 hop edge");
    tick(1'b0, 4'd0, '0, 1'b0, 4'd0, 4'd3, "R5 hop applied");
    tick(1'b0, 4'd0, '0, 1'b0, 4'd0, 4'd3, "R5 hop steady");
    // R6: out-of-range select freezes the phase
    for (int k = 0; k < 4; k++) tick(1'b0, 4'd0, '0, 1'b0, 4'd0, 4'd14, "R6 frozen phase");
    // R7: alternate hops; phase continues without reload
    for (int k = 0; k < 8; k++) tick(1'b0, 4'd0, '0, 1'b0, 4'd0, (k % 2 == 0) ? 4'd2 : 4'd5, "R7 continuity");
    // R8: rewrite the selected register
    tick(1'b1, 4'd5, 16'h7FF3, 1'b0, 4'd0, 4'd5, "R8 write active");
    tick(1'b0, 4'd0, '0, 1'b0, 4'd0, 4'd5, "R8 new step used");
    tick(1'b0, 4'd0, '0, 1'b0, 4'd0, 4'd5, "R8 new step steady");
    // R9: same-edge read/write, out-of-range read, hold without strobe
    tick(1'b1, 4'd7, 16'hBEEF, 1'b1, 4'd7, 4'd5, "R9 read old value");
    tick(1'b0, 4'd0, '0, 1'b1, 4'd7, 4'd5, "R9 read new value");
    tick(1'b0, 4'd0, '0, 1'b1, 4'd13, 4'd5, "R9 out-of-range read");
    tick(1'b0, 4'd0, '0, 1'b1, 4'd1, 4'd5, "R9 read reg1");
    tick(1'b0, 4'd0, '0, 1'b0, 4'd13, 4'd5, "R9 hold");
    // Random mix, R2 accumulation modulo 2^W
    for (int k = 0; k < 3000; k++) begin
      s = 4'($urandom_range(0, 15));
      tick($urandom_range(0, 3) == 0, 4'($urandom_range(0, 15)), W'($urandom),
           $urandom_range(0, 1) == 1, 4'($urandom_range(0, 15)),
           ($urandom_range(0, 4) == 0) ? s : mSel, "R2 random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule